// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of an 8-bit successive-approximation analog-to-digital converter. It has eight analog inputs. It drives the select lines of an external 8:1 analog multiplexer and holds a sampling window of programmable length. It then runs a binary search: it drives an 8-bit code to an external DAC and reads back one comparator bit per converter clock. Finished codes go into a bank of four byte-wide result registers, and a read index selects which one appears on the output.

The converter clock is an enable pulse that the block divides down from the system clock, so all logic stays on one clock. Software picks one of four modes when it starts a pass. A pass converts either one input or a group of four, and it runs either once or repeats until the block is disabled. Completion shows up as a done flag, which can be polled, and as an interrupt line gated by an interrupt enable. Dropping the enable aborts all activity.

Top module: `sar_scan_ctrl`

## Requirements
- R1: With the comparator reporting `cmp_in = 1` when the selected input is at or above `dac_code`, the stored result equals the 8-bit input code exactly, including 0x00 and 0xFF.
- R2: In single-input mode `mux_sel` equals the `ch_sel` captured at start. In group mode it walks base, base+1, base+2, base+3 in ascending order, where base is 4 when `grp_hi` = 1 and 0 otherwise. `mux_sel` does not change during a sampling window.
- R3: In group mode each result goes to the register whose index is the low two bits of its input number. In single-input mode the result goes to register 0.
- R4: Each conversion takes exactly DIV×(S+10) system clocks, where S = `samp_len`+1 converter clocks of sampling (with `sampling` high and `busy` high). A pass of four takes four times that, counted from the clock edge that accepts `start`.
- R5: `done` rises on the edge that stores the last result of a pass. It stays high until a cycle with `stat_rd` = 1. If a pass ends in the same cycle, setting wins.
- R6: `irq` is high exactly while `done` and `irq_en` are both 1.
- R7: In one-shot mode `busy` is low once `done` rises. In repeating mode the next pass starts at once, and later passes overwrite the results with fresh codes.
- R8: A `start` pulse while `busy` is high changes neither the input being converted nor the completion time.
- R9: `enable` = 0 forces idle (`busy` low) on the next edge. It leaves the result registers and `done` unchanged, and a `start` while disabled is ignored.
- R10: After reset `busy`, `done`, `irq`, `sampling` and `mux_sel` are 0, and all four result registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low aborts and idles |
| start | input | 1 | Begin a pass (accepted only while idle and enabled) |
| quad_mode | input | 1 | 1: four-input group, 0: single input |
| cont_mode | input | 1 | 1: repeat passes, 0: one pass |
| grp_hi | input | 1 | Group select: 1 = inputs 4-7, 0 = inputs 0-3 |
| ch_sel | input | 3 | Input number for single-input mode |
| samp_len | input | 4 | Sampling window minus one, in converter clocks |
| irq_en | input | 1 | Interrupt enable |
| stat_rd | input | 1 | Status read strobe; clears done |
| rd_idx | input | 2 | Result register index to show |
| rd_data | output | 8 | Selected result register |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | Pass-complete flag |
| irq | output | 1 | Interrupt request |
| mux_sel | output | 3 | Analog multiplexer select |
| sampling | output | 1 | Sample-and-hold window active |
| dac_code | output | 8 | Trial code to the DAC |
| cmp_in | input | 1 | Comparator: input at or above DAC level |

## Verification
The bench uses input codes at both rails, at mid-scale and one step below it, and in alternating bit patterns. A wrong keep-or-drop decision in the search, or a missing last bit, shows up as a result that is off by one bit. Each pass is timed to the exact system clock. An extra or missing sampling or bookkeeping tick therefore appears as `done` arriving early or late. A group pass in the upper bank, with the other bank holding decoy values, exposes a wrong base, a wrong order or a wrong register index. Mid-conversion restarts, aborts with a stored result on hand, and a repeating pass with changed inputs expose a sequencer that retriggers, clobbers results or stops after one pass.

// File: rtl/sar_pkg.sv
// Package: shared constants and the sequencer state type.
// Assumes eight inputs and four result registers (group of four).
package sar_pkg;
    localparam int NCH   = 8;
    localparam int NBUF  = 4;
    localparam int CH_W  = $clog2(NCH);
    localparam int IDX_W = $clog2(NBUF);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_LOAD,
        ST_BIT,
        ST_WRITE
    } sar_state_t;
endpackage

// File: rtl/sar_tick_div.sv
// Module: converter-clock enable generator.
// Produces a one-cycle tick every DIV system clocks while run is high.
// The count restarts from zero whenever run is low, so the first tick
// comes DIV clocks after run rises. Assumes DIV >= 2.
module sar_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count system clocks within one converter-clock period.
    always_ff @(posedge clk) begin : div_count
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sar_search.sv
// Module: binary-search register.
// On load it sets the MSB trial. On each step it keeps or drops the
// current trial bit according to cmp (1 = input at or above the code)
// and sets the next lower bit. last is high while the LSB is on trial.
module sar_search #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         cmp,
    output logic [W-1:0] code,
    output logic         last
);
    localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] trial;
    logic [W-1:0] mask;

    assign code = trial;
    assign last = mask[0];

    // Trial code and bit-under-test mask.
    always_ff @(posedge clk) begin : search_reg
        if (!rst_n) begin
            trial <= '0;
            mask  <= '0;
        end else if (load) begin
            trial <= MSB;
            mask  <= MSB;
        end else if (step) begin
            trial <= (cmp ? trial : (trial & ~mask)) | (mask >> 1);
            mask  <= mask >> 1;
        end
    end
endmodule

// File: rtl/sar_result_bank.sv
// Module: result register bank with one write port and one read port.
// Assumes the write index is always in range.
module sar_result_bank #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [$clog2(N)-1:0] widx,
    input  logic [W-1:0]         wdata,
    input  logic [$clog2(N)-1:0] ridx,
    output logic [W-1:0]         rdata
);
    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        // Hold one result; written only when addressed.
        always_ff @(posedge clk) begin : hold
            if (!rst_n)                         regs[g] <= '0;
            else if (wr && (widx == g[$clog2(N)-1:0])) regs[g] <= wdata;
        end
    end

    assign rdata = regs[ridx];
endmodule

// File: rtl/sar_scan_ctrl.sv
// Module: top-level sequencer of the successive-approximation converter.
// Runs sample -> load -> 8 decide -> write per input, on converter ticks.
// It walks one input or a group of four, once or repeatedly.
// Assumes the comparator output settles within one converter clock.
module sar_scan_ctrl
    import sar_pkg::*;
#(
    parameter int DIV    = 4,
    parameter int RES_W  = 8,
    parameter int SAMP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic              quad_mode,
    input  logic              cont_mode,
    input  logic              grp_hi,
    input  logic [CH_W-1:0]   ch_sel,
    input  logic [SAMP_W-1:0] samp_len,
    input  logic              irq_en,
    input  logic              stat_rd,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [RES_W-1:0]  rd_data,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic [CH_W-1:0]   mux_sel,
    output logic              sampling,
    output logic [RES_W-1:0]  dac_code,
    input  logic              cmp_in
);
    sar_state_t        state;
    logic [SAMP_W-1:0] scnt;
    logic [CH_W-1:0]   ch;
    logic              cfg_quad, cfg_cont, cfg_hi;
    logic [SAMP_W-1:0] cfg_samp;
    logic              tick, last_bit, pass_end, pass_done, wr_res;
    logic [CH_W-1:0]   start_ch, first_ch;
    logic [IDX_W-1:0]  wr_idx;

    assign busy      = (state != ST_IDLE);
    assign sampling  = (state == ST_SAMPLE);
    assign mux_sel   = ch;
    assign irq       = done && irq_en;
    assign start_ch  = quad_mode ? {grp_hi, {IDX_W{1'b0}}} : ch_sel;
    assign first_ch  = cfg_quad ? {cfg_hi, {IDX_W{1'b0}}} : ch;
    assign pass_end  = !cfg_quad || (ch[IDX_W-1:0] == {IDX_W{1'b1}});
    assign wr_res    = enable && (state == ST_WRITE) && tick;
    assign pass_done = wr_res && pass_end;
    assign wr_idx    = cfg_quad ? ch[IDX_W-1:0] : '0;

    sar_tick_div #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    sar_search #(.W(RES_W)) u_search (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (enable && (state == ST_LOAD) && tick),
        .step  (enable && (state == ST_BIT) && tick),
        .cmp   (cmp_in),
        .code  (dac_code),
        .last  (last_bit)
    );

    sar_result_bank #(.N(NBUF), .W(RES_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_res),
        .widx  (wr_idx),
        .wdata (dac_code),
        .ridx  (rd_idx),
        .rdata (rd_data)
    );

    // Sequencer: phase, sample counter, current input and captured mode.
    always_ff @(posedge clk) begin : seq_fsm
        if (!rst_n) begin
            state    <= ST_IDLE;
            scnt     <= '0;
            ch       <= '0;
            cfg_quad <= 1'b0;
            cfg_cont <= 1'b0;
            cfg_hi   <= 1'b0;
            cfg_samp <= '0;
        end else if (!enable) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    cfg_quad <= quad_mode;
                    cfg_cont <= cont_mode;
                    cfg_hi   <= grp_hi;
                    cfg_samp <= samp_len;
                    ch       <= start_ch;
                    scnt     <= '0;
                    state    <= ST_SAMPLE;
                end
                ST_SAMPLE: if (tick) begin
                    if (scnt == cfg_samp) state <= ST_LOAD;
                    else                  scnt  <= scnt + 1'b1;
                end
                ST_LOAD: if (tick) state <= ST_BIT;
                ST_BIT:  if (tick && last_bit) state <= ST_WRITE;
                ST_WRITE: if (tick) begin
                    scnt <= '0;
                    if (pass_end) begin
                        ch    <= first_ch;
                        state <= cfg_cont ? ST_SAMPLE : ST_IDLE;
                    end else begin
                        ch    <= ch + 1'b1;
                        state <= ST_SAMPLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Completion flag: set at end of pass, cleared by a status read.
    always_ff @(posedge clk) begin : done_flag
        if (!rst_n)         done <= 1'b0;
        else if (pass_done) done <= 1'b1;
        else if (stat_rd)   done <= 1'b0;
    end
endmodule

// File: rtl/sar_scan_chk.sv
// Module: property checker for sar_scan_ctrl, attached with bind.
// Observes ports and the captured group configuration.
module sar_scan_chk #(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            busy,
    input logic            done,
    input logic            irq,
    input logic            irq_en,
    input logic            sampling,
    input logic [CH_W-1:0] mux_sel,
    input logic            cfg_quad,
    input logic            cfg_hi
);
    assert_mux_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && $past(sampling)) |-> $stable(mux_sel));

    assert_group_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && cfg_quad) |-> (mux_sel[CH_W-1] == cfg_hi));

    assert_sample_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sampling |-> busy);

    assert_done_after_work_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && done));

    assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy);
endmodule

bind sar_scan_ctrl sar_scan_chk #(.CH_W(sar_pkg::CH_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .busy     (busy),
    .done     (done),
    .irq      (irq),
    .irq_en   (irq_en),
    .sampling (sampling),
    .mux_sel  (mux_sel),
    .cfg_quad (cfg_quad),
    .cfg_hi   (cfg_hi)
);

// File: tb/sar_scan_ctrl_tb.sv
// Bench: table-driven passes, then directed tests for reset and corner cases.
module sar_scan_ctrl_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, start = 1'b0, quad_mode = 1'b0, cont_mode = 1'b0;
    logic       grp_hi = 1'b0, irq_en = 1'b0, stat_rd = 1'b0;
    logic [2:0] ch_sel = '0;
    logic [3:0] samp_len = '0;
    logic [1:0] rd_idx = '0;
    logic [7:0] rd_data, dac_code;
    logic       busy, done, irq, sampling, cmp_in;
    logic [2:0] mux_sel;
    logic [7:0] ain [8];
    int         cyc = 0;
    int         n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Analog model: comparator against the selected input.
    assign cmp_in = (ain[mux_sel] >= dac_code);

    sar_scan_ctrl #(.DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .quad_mode(quad_mode), .cont_mode(cont_mode), .grp_hi(grp_hi),
        .ch_sel(ch_sel), .samp_len(samp_len), .irq_en(irq_en),
        .stat_rd(stat_rd), .rd_idx(rd_idx), .rd_data(rd_data),
        .busy(busy), .done(done), .irq(irq), .mux_sel(mux_sel),
        .sampling(sampling), .dac_code(dac_code), .cmp_in(cmp_in)
    );

    // fields: quad, hi, ch[2:0], samp[3:0], v0..v3
    localparam logic [40:0] VEC [4] = '{
        {1'b0, 1'b0, 3'd3, 4'd0,  8'hA5, 8'h00, 8'h00, 8'h00},
        {1'b0, 1'b0, 3'd7, 4'd15, 8'h00, 8'h00, 8'h00, 8'h00},
        {1'b1, 1'b0, 3'd0, 4'd2,  8'hFF, 8'h01, 8'h80, 8'h7F},
        {1'b1, 1'b1, 3'd0, 4'd1,  8'h55, 8'hAA, 8'h0F, 8'hF0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_res(input int idx, output int val);
        rd_idx = idx[1:0];
        #1 val = rd_data;
    endtask

    task automatic clear_done();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    // Pulse start; returns the cycle stamp of the accepting edge.
    task automatic pulse_start(output int c0);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        c0 = cyc;
    endtask

    task automatic wait_done(input int c0, output int took);
        int guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        took = cyc - c0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        int c0, took, v, ncv, s, base;
        for (int i = 0; i < 8; i++) ain[i] = 8'h33;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 busy", busy, 0);
        chk("R10 done", done, 0);
        chk("R10 irq", irq, 0);
        chk("R10 sampling", sampling, 0);
        chk("R10 mux_sel", mux_sel, 0);
        for (int k = 0; k < 4; k++) begin
            read_res(k, v);
            chk("R10 result", v, 0);
        end
        enable = 1'b1;

        // Table walk: R1, R2, R3, R4, R7 (one-shot)
        for (int n = 0; n < 4; n++) begin
            logic [40:0] e;
            e = VEC[n];
            clear_done();
            for (int i = 0; i < 8; i++) ain[i] = 8'h33;
            quad_mode = e[40]; grp_hi = e[39]; ch_sel = e[38:36];
            samp_len = e[35:32]; cont_mode = 1'b0;
            base = e[39] ? 4 : 0;
            if (e[40]) for (int k = 0; k < 4; k++) ain[base+k] = e[31-8*k -: 8];
            else       ain[e[38:36]] = e[31:24];
            ncv = e[40] ? 4 : 1;
            s = int'(e[35:32]) + 1;
            pulse_start(c0);
            chk("R2 first input", mux_sel, e[40] ? base : int'(e[38:36]));
            chk("R4 sampling window open", sampling, 1);
            wait_done(c0, took);
            chk("R4 pass length", took, ncv * DIV * (s + 10));
            chk("R7 one-shot idle", busy, 0);
            if (e[40]) begin
                for (int k = 0; k < 4; k++) begin
                    read_res(k, v);
                    chk("R3 R1 group result", v, int'(e[31-8*k -: 8]));
                end
            end else begin
                read_res(0, v);
                chk("R3 R1 single result", v, int'(e[31:24]));
            end
        end

        // R6 and R5: interrupt gating and status-read clear
        @(negedge clk);
        chk("R5 done held", done, 1);
        chk("R6 irq masked", irq, 0);
        irq_en = 1'b1;
        #1 chk("R6 irq raised", irq, 1);
        clear_done();
        chk("R5 done cleared", done, 0);
        chk("R6 irq dropped", irq, 0);

        // R8: start while busy is ignored
        quad_mode = 1'b0; ch_sel = 3'd1; samp_len = 4'd3;
        ain[1] = 8'h3C; ain[6] = 8'h99;
        pulse_start(c0);
        repeat (10) @(negedge clk);
        ch_sel = 3'd6; samp_len = 4'd0;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R8 input unchanged", mux_sel, 1);
        wait_done(c0, took);
        chk("R8 timing unchanged", took, DIV * (4 + 10));
        read_res(0, v);
        chk("R8 result from first", v, 8'h3C);
        clear_done();

        // R9: abort keeps results, start while disabled ignored
        ch_sel = 3'd2; ain[2] = 8'hEE;
        pulse_start(c0);
        repeat (20) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R9 abort idle", busy, 0);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (60) @(negedge clk);
        chk("R9 start ignored", busy, 0);
        chk("R9 done untouched", done, 0);
        read_res(0, v);
        chk("R9 result kept", v, 8'h3C);
        enable = 1'b1;

        // R7: repeating group pass refreshes results
        quad_mode = 1'b1; cont_mode = 1'b1; grp_hi = 1'b0; samp_len = 4'd0;
        for (int k = 0; k < 4; k++) ain[k] = 8'(8'h10 + k);
        pulse_start(c0);
        wait_done(c0, took);
        chk("R7 first pass length", took, 4 * DIV * 11);
        chk("R7 repeating busy", busy, 1);
        for (int k = 0; k < 4; k++) ain[k] = 8'(8'hC0 + k);
        clear_done();
        c0 = cyc;
        wait_done(c0, took);
        for (int k = 0; k < 4; k++) begin
            read_res(k, v);
            chk("R7 refreshed result", v, 8'hC0 + k);
        end
        chk("R5 done on repeat pass", done, 1);
        enable = 1'b0;
        @(negedge clk);
        chk("R9 repeat stopped", busy, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule